// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single DMA channel that carries bytes between memory and one internal peripheral. It has two descriptor slots. Each slot holds a base address and a byte count, so software can program the following buffer while the current one is still moving. The channel works through the slots in alternation. One byte at a time, it issues single-beat memory requests and exchanges bytes with the peripheral over valid/ready streams.

Software controls the channel through a small register window. The window holds control, interrupt, port-select, status, remaining-count and slot registers. A four-level state (idle, stall, on, next) reports how many buffers are armed. Stall, next-free-buffer and error flags feed one interrupt line.

The direction is set by control bit 2. With that bit at 0, bytes read from memory leave on the outbound stream. With it at 1, bytes accepted on the inbound stream are written to memory.

Stream rules are as follows. The outbound byte is offered with `out_valid`. It stays valid, with its data unchanged, until `out_ready` is seen high at a clock edge. The inbound stream raises `in_ready` only while the channel waits for a byte. A byte is taken on the edge where `in_valid` and `in_ready` are both high. The memory request holds its address and data until `mem_ack` or `mem_err` comes back.

Top module: `pdma_channel`

## Requirements
- R1: After reset, every register reads 0, the state is IDLE, `irq` is low, and `mem_req`, `out_valid` and `in_ready` are low.
- R2: Status offset 0x0C bits [5:4] give the state. IDLE=0 means disabled with no buffer, STALL=1 means enabled with no buffer, ON=2 means one buffer armed, and NEXT=3 means two buffers armed.
- R3: Slot s has its count at 0x20+0x10*s and its base at 0x24+0x10*s. A base write arms the slot only if the slot is unarmed and enable (control bit 4) is set. Count or base writes to an armed slot are ignored.
- R4: Armed slots are consumed in alternation, and bytes move in address order from each slot's base.
- R5: With control bit 2 at 0, each byte is read from memory and offered on the outbound stream. Under back-pressure, `out_valid` and `out_data` hold.
- R6: With control bit 2 at 1, each byte accepted on the inbound stream is written to memory at the next address.
- R7: Offset 0x14 shows the bytes left in the active slot. The slot registers read back live values: the count falls by one and the base rises by one for each byte moved.
- R8: A slot armed with count 0 retires without any transfer.
- R9: Interrupt register (0x04) bit 1 sets on NEXT to ON and clears when the state leaves ON. Bit 0 sets on ON to STALL and clears when the state leaves STALL.
- R10: An error response from memory sets interrupt bit 3, abandons the current buffer and moves to the other slot. Writing 1 to bit 3 clears it.
- R11: `irq` is the OR of each flag ANDed with its enable: control bit 0 for stall, bit 1 for next-free-buffer and bit 3 for error.
- R12: Clearing enable lets armed buffers finish. The channel then passes through STALL and goes to IDLE.
- R13: Once raised, `mem_req` holds its address until acknowledged or errored.
- R14: The port-select register at 0x08 drives `periph_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Channel interrupt |
| periph_sel | output | 4 | Selected peripheral port |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| mem_ack | input | 1 | Memory request completed |
| mem_err | input | 1 | Memory request failed |
| out_valid | output | 1 | Outbound byte valid |
| out_data | output | 8 | Outbound byte |
| out_ready | input | 1 | Peripheral takes outbound byte |
| in_valid | input | 1 | Inbound byte valid |
| in_data | input | 8 | Inbound byte |
| in_ready | output | 1 | Channel takes inbound byte |

## Verification
The assertions assume that memory raises at most one of `mem_ack` and `mem_err`, and does so only while `mem_req` is high. They also assume that software alternates slots and does not flip direction while a byte is in flight. The bench's memory responder answers each request once, after a one-cycle wait, and raises the error only at one chosen address. All register writes are made from the stimulus with the direction fixed for the whole of each transfer phase.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int RA_W   = 8;
  localparam int PSEL_W = 4;

  localparam logic [RA_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [RA_W-1:0] OFS_INTR   = 8'h04;
  localparam logic [RA_W-1:0] OFS_PSEL   = 8'h08;
  localparam logic [RA_W-1:0] OFS_STAT   = 8'h0C;
  localparam logic [RA_W-1:0] OFS_REMAIN = 8'h14;
  localparam logic [RA_W-1:0] OFS_SLOT   = 8'h20;
  localparam logic [RA_W-1:0] OFS_STRIDE = 8'h10;

  localparam int CB_STALL_IE = 0;
  localparam int CB_NFB_IE   = 1;
  localparam int CB_DIR      = 2;
  localparam int CB_ERR_IE   = 3;
  localparam int CB_EN       = 4;
  localparam int CTRL_W      = 5;

  localparam int IB_STALL = 0;
  localparam int IB_NFB   = 1;
  localparam int IB_ERR   = 3;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_STALL = 2'd1,
    CH_ON    = 2'd2,
    CH_NEXT  = 2'd3
  } ch_state_e;

  function automatic ch_state_e level_of(input logic [1:0] armed, input logic idle);
    case (armed)
      2'b11:   return CH_NEXT;
      2'b00:   return idle ? CH_IDLE : CH_STALL;
      default: return CH_ON;
    endcase
  endfunction
endpackage

// File: rtl/pdma_slots.sv
module pdma_slots #(
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [1:0]                  wr_cnt,
  input  logic [1:0]                  wr_base,
  input  logic [REG_W-1:0]            wdata,
  input  logic                        step,
  input  logic                        abort,
  output logic [1:0]                  armed_q,
  output logic [1:0]                  armed_d,
  output logic                        busy,
  output logic [REG_W-1:0]            act_base,
  output logic [CNT_W-1:0]            act_cnt,
  output logic [1:0][REG_W-1:0]       base_rd,
  output logic [1:0][CNT_W-1:0]       cnt_rd
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0][REG_W-1:0] base_q;
  logic [NSLOT-1:0][CNT_W-1:0] cnt_q;
  logic                        cur_q;
  logic                        retire;

  assign act_base = base_q[cur_q];
  assign act_cnt  = cnt_q[cur_q];
  assign busy     = armed_q[cur_q] && (act_cnt != '0);
  assign retire   = armed_q[cur_q] && (abort || act_cnt == '0);
  assign base_rd  = base_q;
  assign cnt_rd   = cnt_q;

  always_comb begin
    armed_d = armed_q;
    for (int s = 0; s < NSLOT; s++) begin
      if (wr_base[s] && !armed_q[s] && en) armed_d[s] = 1'b1;
      if (retire && cur_q == s[0]) armed_d[s] = 1'b0;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[s] <= '0;
        cnt_q[s]  <= '0;
      end else if (!armed_q[s]) begin
        if (wr_cnt[s])  cnt_q[s]  <= wdata[CNT_W-1:0];
        if (wr_base[s]) base_q[s] <= wdata;
      end else if (step && cur_q == s) begin
        cnt_q[s]  <= cnt_q[s] - CNT_W'(1);
        base_q[s] <= base_q[s] + REG_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= '0;
      cur_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (retire) cur_q <= ~cur_q;
      else if (!armed_q[cur_q] && armed_q[~cur_q]) cur_q <= ~cur_q;
    end
  end

  // a byte step only ever lands on a live buffer with bytes left
  assert_step_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (armed_q[cur_q] && act_cnt != '0));

  // a step shrinks the active count by exactly one on the next edge
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !abort) |=> (act_cnt == $past(act_cnt) - CNT_W'(1)));
endmodule

// File: rtl/pdma_mover.sv
module pdma_mover #(
  parameter int REG_W = 32,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir,
  input  logic             go,
  input  logic [REG_W-1:0] addr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [REG_W-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  input  logic             out_ready,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  output logic             step,
  output logic             abort
);
  typedef enum logic [1:0] {PH_IDLE, PH_MEM, PH_PERI} phase_e;

  phase_e      ph_q;
  logic        dir_q;
  logic [DW-1:0] hold_q;

  assign mem_req   = (ph_q == PH_MEM);
  assign mem_we    = dir_q;
  assign mem_addr  = addr;
  assign mem_wdata = hold_q;
  assign out_valid = (ph_q == PH_PERI) && !dir_q;
  assign out_data  = hold_q;
  assign in_ready  = (ph_q == PH_PERI) && dir_q;

  always_comb begin
    step  = 1'b0;
    abort = 1'b0;
    if (ph_q == PH_MEM) begin
      abort = mem_err;
      step  = mem_ack && !mem_err && dir_q;
    end else if (ph_q == PH_PERI) begin
      step  = !dir_q && out_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      dir_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (go) begin
          dir_q <= dir;
          ph_q  <= dir ? PH_PERI : PH_MEM;
        end
        PH_MEM: begin
          if (mem_err) ph_q <= PH_IDLE;
          else if (mem_ack) begin
            if (dir_q) ph_q <= PH_IDLE;
            else begin
              hold_q <= mem_rdata;
              ph_q   <= PH_PERI;
            end
          end
        end
        PH_PERI: begin
          if (dir_q) begin
            if (in_valid) begin
              hold_q <= in_data;
              ph_q   <= PH_MEM;
            end
          end else if (out_ready) ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_one_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, out_valid, in_ready}));
endmodule

// File: rtl/pdma_csr.sv
module pdma_csr
  import pdma_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [RA_W-1:0]       reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [1:0]            armed_q,
  input  logic [1:0]            armed_d,
  input  logic [CNT_W-1:0]      act_cnt,
  input  logic [1:0][REG_W-1:0] base_rd,
  input  logic [1:0][CNT_W-1:0] cnt_rd,
  input  logic                  abort,
  output logic                  en,
  output logic                  dir,
  output logic [1:0]            wr_cnt,
  output logic [1:0]            wr_base,
  output logic                  irq,
  output logic [PSEL_W-1:0]     periph_sel
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [PSEL_W-1:0] psel_q;
  logic              idle_q, idle_d, en_d;
  logic              stall_f, nfb_f, err_f;
  logic              wr_ctrl, wr_intr, wr_psel;
  ch_state_e         now, nxt;

  assign wr_ctrl = reg_wr && reg_addr == OFS_CTRL;
  assign wr_intr = reg_wr && reg_addr == OFS_INTR;
  assign wr_psel = reg_wr && reg_addr == OFS_PSEL;

  for (genvar s = 0; s < 2; s++) begin : g_dec
    localparam logic [RA_W-1:0] CNT_OFS  = OFS_SLOT + RA_W'(s) * OFS_STRIDE;
    localparam logic [RA_W-1:0] BASE_OFS = CNT_OFS + RA_W'(4);
    assign wr_cnt[s]  = reg_wr && reg_addr == CNT_OFS;
    assign wr_base[s] = reg_wr && reg_addr == BASE_OFS;
  end

  assign en         = ctrl_q[CB_EN];
  assign dir        = ctrl_q[CB_DIR];
  assign periph_sel = psel_q;
  assign en_d       = wr_ctrl ? reg_wdata[CB_EN] : en;

  assign now    = level_of(armed_q, idle_q);
  assign idle_d = (armed_d == 2'b00) && !en_d && (now == CH_STALL || now == CH_IDLE);
  assign nxt    = level_of(armed_d, idle_d);

  assign irq = (stall_f && ctrl_q[CB_STALL_IE]) || (nfb_f && ctrl_q[CB_NFB_IE]) ||
               (err_f && ctrl_q[CB_ERR_IE]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      psel_q  <= '0;
      idle_q  <= 1'b1;
      stall_f <= 1'b0;
      nfb_f   <= 1'b0;
      err_f   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (wr_psel) psel_q <= reg_wdata[PSEL_W-1:0];
      idle_q  <= idle_d;
      stall_f <= (nxt == CH_STALL) && (stall_f || now == CH_ON);
      nfb_f   <= (nxt == CH_ON) && (nfb_f || now == CH_NEXT);
      err_f   <= abort || (err_f && !(wr_intr && reg_wdata[IB_ERR]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
      OFS_INTR: begin
        reg_rdata[IB_STALL] = stall_f;
        reg_rdata[IB_NFB]   = nfb_f;
        reg_rdata[IB_ERR]   = err_f;
      end
      OFS_PSEL:   reg_rdata[PSEL_W-1:0] = psel_q;
      OFS_STAT:   reg_rdata[5:4] = now;
      OFS_REMAIN: reg_rdata[CNT_W-1:0] = act_cnt;
      8'h20:      reg_rdata[CNT_W-1:0] = cnt_rd[0];
      8'h24:      reg_rdata = base_rd[0];
      8'h30:      reg_rdata[CNT_W-1:0] = cnt_rd[1];
      8'h34:      reg_rdata = base_rd[1];
      default:    reg_rdata = '0;
    endcase
  end

  assert_stall_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_f |-> (now == CH_STALL));

  assert_nfb_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nfb_f |-> (now == CH_ON));

  assert_next_drops_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (now == CH_NEXT) |=> (now != CH_STALL && now != CH_IDLE));

  assert_idle_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (now == CH_IDLE) |-> !en);
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 16,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic [PSEL_W-1:0] periph_sel,
  output logic              mem_req,
  output logic              mem_we,
  output logic [REG_W-1:0]  mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  input  logic              out_ready,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              in_ready
);
  logic [1:0]            armed_q, armed_d, wr_cnt, wr_base;
  logic                  en, dir, busy, step, abort;
  logic [REG_W-1:0]      act_base;
  logic [CNT_W-1:0]      act_cnt;
  logic [1:0][REG_W-1:0] base_rd;
  logic [1:0][CNT_W-1:0] cnt_rd;

  pdma_csr #(.REG_W(REG_W), .CNT_W(CNT_W)) csr_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .armed_q(armed_q),
    .armed_d(armed_d), .act_cnt(act_cnt), .base_rd(base_rd), .cnt_rd(cnt_rd),
    .abort(abort), .en(en), .dir(dir), .wr_cnt(wr_cnt), .wr_base(wr_base),
    .irq(irq), .periph_sel(periph_sel)
  );

  pdma_slots #(.REG_W(REG_W), .CNT_W(CNT_W)) slots_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_cnt(wr_cnt), .wr_base(wr_base),
    .wdata(reg_wdata), .step(step), .abort(abort), .armed_q(armed_q),
    .armed_d(armed_d), .busy(busy), .act_base(act_base), .act_cnt(act_cnt),
    .base_rd(base_rd), .cnt_rd(cnt_rd)
  );

  pdma_mover #(.REG_W(REG_W), .DW(DW)) mover_i (
    .clk(clk), .rst_n(rst_n), .dir(dir), .go(busy), .addr(act_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .step(step), .abort(abort)
  );
endmodule

// File: tb/pdma_channel_tb_top.sv
module pdma_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [3:0]  periph_sel;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;

  int checks = 0;
  int errors = 0;
  int tx_seen = 0;
  int viol = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [7:0]  txq[$];
  logic [15:0] wq[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] mdata(input logic [31:0] a);
    return a[7:0] * 8'd7 + 8'h3C;
  endfunction

  assign mem_rdata = mdata(mem_addr);

  pdma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .periph_sel(periph_sel), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wr   = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wait_state(input string req, input logic [1:0] st);
    logic [31:0] d;
    int n = 0;
    rd(8'h0C, d);
    while (d[5:4] !== st && n < 200) begin
      rd(8'h0C, d);
      n++;
    end
    chk(req, {30'd0, d[5:4]}, {30'd0, st});
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic got = 1'b0;
    in_valid = 1'b1;
    in_data  = b;
    while (!got) begin
      #2 got = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // memory responder: one wait cycle, then ack or error; write scoreboard
  initial begin
    logic        waited = 1'b0;
    logic [31:0] last = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      mem_err = 1'b0;
      if (mem_req) begin
        if (waited) begin
          if (mem_addr !== last) viol++;
          waited = 1'b0;
          if (mem_addr == err_addr) mem_err = 1'b1;
          else begin
            mem_ack = 1'b1;
            if (mem_we) begin
              if (wq.size() == 0) chk("R6 unexpected memory write", {16'd0, mem_addr[7:0], mem_wdata}, 32'hFFFF);
              else chk("R6 memory write addr/data", {16'd0, mem_addr[7:0], mem_wdata}, {16'd0, wq.pop_front()});
            end
          end
        end else begin
          waited = 1'b1;
          last   = mem_addr;
        end
      end else waited = 1'b0;
    end
  end

  // outbound monitor: compare each handshaken byte against the queue
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (out_valid && out_ready) begin
        tx_seen++;
        if (txq.size() == 0) chk("R4 R5 unexpected outbound byte", {24'd0, out_data}, 32'hFFFF);
        else chk("R4 R5 outbound byte order", {24'd0, out_data}, {24'd0, txq.pop_front()});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int rec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h0C, d); chk("R1 status idle", d, 0);
    rd(8'h04, d); chk("R1 intr", d, 0);
    rd(8'h14, d); chk("R1 remain", d, 0);
    chk("R1 outputs", {28'd0, irq, mem_req, out_valid, in_ready}, 0);

    // R2 enable -> STALL, no flag yet
    wr(8'h00, 32'h1B);
    rd(8'h0C, d); chk("R2 status stall", d, 32'h10);
    rd(8'h04, d); chk("R9 no stall flag on enable", d, 0);

    // R2 R3 arm two slots under back-pressure
    wr(8'h20, 4); wr(8'h24, 32'h10);
    rd(8'h0C, d); chk("R2 status on", d, 32'h20);
    wr(8'h30, 3); wr(8'h34, 32'h40);
    rd(8'h0C, d); chk("R2 status next", d, 32'h30);
    settle(6);
    chk("R5 held valid", {31'd0, out_valid}, 1);
    chk("R5 held data", {24'd0, out_data}, {24'd0, mdata(32'h10)});
    rd(8'h14, d); chk("R7 remain before step", d, 4);
    wr(8'h24, 32'h99); wr(8'h20, 9);
    rd(8'h24, d); chk("R3 armed base write ignored", d, 32'h10);
    rd(8'h20, d); chk("R3 armed count write ignored", d, 4);

    for (int i = 0; i < 4; i++) txq.push_back(mdata(32'h10 + i));
    for (int i = 0; i < 3; i++) txq.push_back(mdata(32'h40 + i));
    @(negedge clk); out_ready = 1'b1;
    wait_state("R9 reach on", 2'd1 + 2'd1);
    rd(8'h04, d); chk("R9 nfb flag on NEXT to ON", d, 32'h2);
    chk("R11 irq nfb", {31'd0, irq}, 1);
    wait_state("R9 reach stall", 2'd1);
    rd(8'h04, d); chk("R9 stall set nfb cleared", d, 32'h1);
    rd(8'h34, d); chk("R7 live base after slot1", d, 32'h43);
    settle(2);
    chk("R4 all bytes out", txq.size(), 0);

    // R8 zero-count buffer
    rec = tx_seen;
    wr(8'h20, 0); wr(8'h24, 32'h20);
    settle(4);
    rd(8'h0C, d); chk("R8 back to stall", d, 32'h10);
    chk("R8 no transfer", tx_seen, rec);
    rd(8'h24, d); chk("R8 base untouched", d, 32'h20);

    // R10 memory error mid-buffer
    out_ready = 1'b0;
    err_addr = 32'hE0;
    wr(8'h20, 3); wr(8'h24, 32'hDF);
    wr(8'h30, 2); wr(8'h34, 32'h80);
    txq.push_back(mdata(32'hDF));
    txq.push_back(mdata(32'h80));
    txq.push_back(mdata(32'h81));
    @(negedge clk); out_ready = 1'b1;
    wait_state("R10 finish after error", 2'd1);
    rd(8'h04, d); chk("R10 error flag", d, 32'h9);
    chk("R11 irq error", {31'd0, irq}, 1);
    rd(8'h34, d); chk("R10 moved to other slot", d, 32'h82);
    wr(8'h04, 32'h8);
    rd(8'h04, d); chk("R10 error write-one-clear", d, 32'h1);
    chk("R10 bytes", txq.size(), 0);
    err_addr = 32'hFFFF_FFFF;

    // R14 port select
    wr(8'h08, 5);
    settle(1);
    chk("R14 periph_sel", {28'd0, periph_sel}, 5);
    rd(8'h08, d); chk("R14 readback", d, 5);

    // R12 disable while ON
    out_ready = 1'b0;
    wr(8'h20, 3); wr(8'h24, 32'h30);
    wr(8'h00, 32'h0B);
    rd(8'h0C, d); chk("R12 still on after disable", d, 32'h20);
    for (int i = 0; i < 3; i++) txq.push_back(mdata(32'h30 + i));
    @(negedge clk); out_ready = 1'b1;
    wait_state("R12 reach idle", 2'd0);
    chk("R12 buffer finished", txq.size(), 0);
    wr(8'h30, 2); wr(8'h34, 32'h50);
    settle(5);
    rd(8'h0C, d); chk("R3 disabled base write does not arm", d, 0);
    chk("R3 no request when disabled", {31'd0, mem_req}, 0);

    // R6 peripheral to memory, interrupts masked
    out_ready = 1'b0;
    wr(8'h00, 32'h14);
    rd(8'h0C, d); chk("R2 stall in rx", d, 32'h10);
    wr(8'h30, 3); wr(8'h34, 32'h60);
    wq.push_back({8'h60, 8'hA5});
    wq.push_back({8'h61, 8'h5A});
    wq.push_back({8'h62, 8'hC3});
    @(negedge clk);
    send_byte(8'hA5);
    send_byte(8'h5A);
    send_byte(8'hC3);
    wait_state("R6 rx done", 2'd1);
    chk("R6 all writes", wq.size(), 0);
    rd(8'h04, d); chk("R9 stall flag rx", d, 32'h1);
    chk("R11 irq masked", {31'd0, irq}, 0);
    settle(1);
    chk("R6 in_ready low", {31'd0, in_ready}, 0);
    chk("R13 request held", viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule